// File: doc/BRIEF.md
# Multiplexed Narrow-Device Bus Controller

This block connects a 32-bit internal request port, used by a core or a cache, to one external bus on which address and data share the same lines. Each accepted request becomes a series of external cycles. Every cycle starts with a one-cycle address phase and continues with a data phase that the addressed device can stretch with a ready signal. The number of cycles, the byte lanes used and the byte order all depend on a fixed table of address regions. Each region gives a device width of 8, 16 or 32 bits, a byte order, and whether the device accepts bursts.

Single accesses of 1, 2 or 4 bytes may start at any byte address. The controller splits each one into the aligned device cycles needed to cover it, then merges the returned bytes or enables only the affected lanes. Line requests move four beats of the region width for cache fills and flushes. A burst-capable region receives them as a single address phase followed by four beats; any other region receives four separate cycles. An external master can take the bus between requests with a request/grant handshake. While it holds the bus, the controller leaves the lines alone and starts no cycle.

Top module: `bus_ctl_top`

## Requirements
- R1: Every external cycle begins with exactly one clock of address phase (`bus_ale`=1, `bus_oe`=1, `bus_ad_o` = the device-aligned address). The data phase on the same lines follows in the very next clock.
- R2: Region width code 0/1/2 means an 8/16/32-bit device. An aligned 4-byte access becomes 4/2/1 external cycles. In a data phase, the byte at aligned address A+l travels on bits [8l+7:8l], and `bus_be` bit l marks it.
- R3: A line request (`req_burst`=1) to a region with bursts enabled produces one address phase and then four data beats of W bytes each. The base address is `req_addr` aligned down to 4·W, and the address implied by each beat advances by W. Line byte i (bits [8i+7:8i] of `req_wline`/`rsp_rline`) belongs to address base+i, and unused upper line bytes read as zero.
- R4: A line request to a region with bursts disabled produces four separate cycles, each with its own address phase, at base, base+W, base+2W and base+3W.
- R5: In a little-endian region, the byte at the lowest address is the least significant byte of the value. In a big-endian region, it is the most significant byte. Request sizes are coded 0=1 byte, 1=2 bytes, 2=4 bytes, and the value sits in the low bytes of `req_wdata`/`rsp_rdata`, zero-extended on reads.
- R6: A single access of any size at any address uses the aligned device cycles that cover exactly its bytes, in rising address order. Writes enable only the lanes of those bytes, and reads merge bytes from every cycle.
- R7: Region attributes come from the lowest-indexed entry whose `(addr & mask) == base`. An address that matches no entry is treated as 32-bit, big-endian, without bursts.
- R8: While `bus_rdy` is low in a data phase, the phase is held with unchanged lines and strobes. A wait state never causes an extra address phase inside a burst.
- R9: `ext_req` seen while the controller is idle raises `ext_gnt` on the next clock. While the grant is held, `req_ready` is low and the outputs `bus_ale`, `bus_oe`, `bus_rd`, `bus_wr` are 0. `ext_req` wins over a pending request. When `ext_req` drops, the grant falls on the next clock.
- R10: `rsp_valid` pulses for exactly one clock, in the clock after the final data beat is completed.
- R11: During and after reset, the controller is idle, with `req_ready`=1 and all bus strobes, `ext_gnt` and `rsp_valid` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Internal request present |
| req_ready | output | 1 | Request accepted on this clock edge when both are high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | Line request of four beats |
| req_size | input | 2 | Single access size: 0=1, 1=2, 2=4 bytes |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write value for single accesses |
| req_wline | input | 128 | Write line for line requests |
| rsp_valid | output | 1 | Request finished |
| rsp_rdata | output | 32 | Read value for single accesses |
| rsp_rline | output | 128 | Read line for line requests |
| bus_ad_o | output | 32 | Multiplexed address/write data out |
| bus_ad_i | input | 32 | Read data from the lines |
| bus_oe | output | 1 | Controller drives the lines |
| bus_ale | output | 1 | Address phase strobe |
| bus_rd | output | 1 | Read data phase |
| bus_wr | output | 1 | Write data phase |
| bus_be | output | 4 | Active byte lanes in the data phase |
| bus_rdy | input | 1 | Device completes the current data beat |
| ext_req | input | 1 | External master wants the bus |
| ext_gnt | output | 1 | Bus granted to the external master |

## Verification
A wrong cycle pointer or an end-of-request compare shows up at the ports as too many or too few address strobes. It appears within the same request, because the bench's device model counts address phases and beats per request. A wrong lane index or endian choice leaves a misplaced byte in the model's memory, or a wrong merged value, which is visible when that request's response arrives. A stale grant or a hold that fails under wait states shows up as strobes during a grant or as lines changing while ready is low, which the bound properties catch on the next clock.

// File: rtl/bc_pkg.sv
package bc_pkg;
  typedef struct packed {
    logic       le;     // 1 = little-endian
    logic       burst;  // region accepts bursts
    logic [1:0] wcode;  // 0 = 8 bit, 1 = 16 bit, 2 = 32 bit
  } bc_attr_t;

  localparam bc_attr_t BC_DEFAULT_ATTR = '{le: 1'b0, burst: 1'b0, wcode: 2'd2};

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA, ST_RESP} bc_state_e;

  function automatic logic [2:0] width_bytes(input logic [1:0] wc);
    case (wc)
      2'd0:    width_bytes = 3'd1;
      2'd1:    width_bytes = 3'd2;
      default: width_bytes = 3'd4;
    endcase
  endfunction

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    size_bytes = 3'd1;
      2'd1:    size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/bc_region_lookup.sv
module bc_region_lookup
  import bc_pkg::*;
#(
  parameter int DW    = 32,
  parameter int N_REG = 3,
  parameter logic [N_REG*DW-1:0] REG_BASE = '0,
  parameter logic [N_REG*DW-1:0] REG_MASK = '0,
  parameter logic [N_REG*$bits(bc_attr_t)-1:0] REG_ATTR = '0
) (
  input  logic [DW-1:0] addr,
  output bc_attr_t      attr
);
  localparam int AB = $bits(bc_attr_t);

  logic [N_REG-1:0] hit;

  for (genvar g = 0; g < N_REG; g++) begin : g_cmp
    assign hit[g] = ((addr & REG_MASK[g*DW +: DW]) == REG_BASE[g*DW +: DW]);
  end

  // lowest index wins: scan from the top down
  always_comb begin
    attr = BC_DEFAULT_ATTR;
    for (int i = N_REG - 1; i >= 0; i--) begin
      if (hit[i]) attr = bc_attr_t'(REG_ATTR[i*AB +: AB]);
    end
  end
endmodule

// File: rtl/bc_lane_steer.sv
module bc_lane_steer #(
  parameter int DW     = 32,
  parameter int LINE_W = 4 * DW
) (
  input  logic              burst_mode,
  input  logic              le,
  input  logic [2:0]        wb,        // device width in bytes
  input  logic [2:0]        n,         // access size in bytes
  input  logic [DW-1:0]     req_addr,
  input  logic [DW-1:0]     cyc_addr,
  input  logic [1:0]        beat,
  input  logic [DW-1:0]     wval,
  input  logic [LINE_W-1:0] wline,
  input  logic [DW-1:0]     rd_lanes,
  input  logic [DW-1:0]     acc_in,
  input  logic [LINE_W-1:0] line_in,
  output logic [DW-1:0]     wlanes,
  output logic [DW/8-1:0]   be,
  output logic [DW-1:0]     acc_out,
  output logic [LINE_W-1:0] line_out
);
  localparam int NB = DW / 8;

  always_comb begin
    wlanes   = '0;
    be       = '0;
    acc_out  = acc_in;
    line_out = line_in;
    for (int l = 0; l < NB; l++) begin
      logic [DW-1:0] ba;
      logic [DW-1:0] off;
      logic [1:0]    v;
      int            idx;
      ba  = cyc_addr + DW'(l);
      off = ba - req_addr;
      v   = le ? off[1:0] : 2'(n - 3'd1 - off[2:0]);
      idx = int'(beat) * int'(wb) + l;
      if (burst_mode) begin
        if (l < int'(wb)) begin
          be[l]                 = 1'b1;
          wlanes[8*l +: 8]      = wline[8*idx +: 8];
          line_out[8*idx +: 8]  = rd_lanes[8*l +: 8];
        end
      end else if ((l < int'(wb)) && (off < DW'(n))) begin
        be[l]              = 1'b1;
        wlanes[8*l +: 8]   = wval[8*v +: 8];
        acc_out[8*v +: 8]  = rd_lanes[8*l +: 8];
      end
    end
  end
endmodule

// File: rtl/bus_ctl_top.sv
module bus_ctl_top
  import bc_pkg::*;
#(
  parameter int DW    = 32,
  parameter int N_REG = 3,
  parameter logic [N_REG*DW-1:0] REG_BASE = {32'h0000_3000, 32'h0000_2000, 32'h0000_1000},
  parameter logic [N_REG*DW-1:0] REG_MASK = {3{32'hFFFF_F000}},
  parameter logic [N_REG*$bits(bc_attr_t)-1:0] REG_ATTR = {4'b1110, 4'b1001, 4'b0100}
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic                req_burst,
  input  logic [1:0]          req_size,
  input  logic [DW-1:0]       req_addr,
  input  logic [DW-1:0]       req_wdata,
  input  logic [4*DW-1:0]     req_wline,
  output logic                rsp_valid,
  output logic [DW-1:0]       rsp_rdata,
  output logic [4*DW-1:0]     rsp_rline,
  output logic [DW-1:0]       bus_ad_o,
  input  logic [DW-1:0]       bus_ad_i,
  output logic                bus_oe,
  output logic                bus_ale,
  output logic                bus_rd,
  output logic                bus_wr,
  output logic [DW/8-1:0]     bus_be,
  input  logic                bus_rdy,
  input  logic                ext_req,
  output logic                ext_gnt
);
  localparam int NB     = DW / 8;
  localparam int LINE_W = 4 * DW;

  bc_state_e         st;
  bc_attr_t          attr_q, look;
  logic [DW-1:0]     cyc_a, last_a, addr_q, wval_q, acc_q;
  logic [LINE_W-1:0] line_q;
  logic [2:0]        n_q, wb_q, look_wb, req_n;
  logic [1:0]        beat_q;
  logic              wr_q, burst_q, gnt_q;
  logic [DW-1:0]     steer_w, acc_nx;
  logic [NB-1:0]     steer_be;
  logic [LINE_W-1:0] line_nx;
  logic              accept, done;

  bc_region_lookup #(
    .DW(DW), .N_REG(N_REG), .REG_BASE(REG_BASE), .REG_MASK(REG_MASK), .REG_ATTR(REG_ATTR)
  ) u_lookup (
    .addr(req_addr),
    .attr(look)
  );

  bc_lane_steer #(.DW(DW), .LINE_W(LINE_W)) u_steer (
    .burst_mode(burst_q),
    .le        (attr_q.le),
    .wb        (wb_q),
    .n         (n_q),
    .req_addr  (addr_q),
    .cyc_addr  (cyc_a),
    .beat      (beat_q),
    .wval      (wval_q),
    .wline     (line_q),
    .rd_lanes  (bus_ad_i),
    .acc_in    (acc_q),
    .line_in   (line_q),
    .wlanes    (steer_w),
    .be        (steer_be),
    .acc_out   (acc_nx),
    .line_out  (line_nx)
  );

  assign look_wb   = width_bytes(look.wcode);
  assign req_n     = size_bytes(req_size);
  assign req_ready = (st == ST_IDLE) && !gnt_q && !ext_req;
  assign accept    = req_valid && req_ready;
  assign done      = burst_q ? (beat_q == 2'd3) : (cyc_a == last_a);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      gnt_q   <= 1'b0;
      attr_q  <= BC_DEFAULT_ATTR;
      cyc_a   <= '0;
      last_a  <= '0;
      addr_q  <= '0;
      wval_q  <= '0;
      acc_q   <= '0;
      line_q  <= '0;
      n_q     <= 3'd4;
      wb_q    <= 3'd4;
      beat_q  <= '0;
      wr_q    <= 1'b0;
      burst_q <= 1'b0;
    end else begin
      gnt_q <= gnt_q ? ext_req : ((st == ST_IDLE) && ext_req);
      case (st)
        ST_IDLE: if (accept) begin
          attr_q  <= look;
          wb_q    <= look_wb;
          n_q     <= req_n;
          addr_q  <= req_addr;
          wval_q  <= req_wdata;
          wr_q    <= req_write;
          burst_q <= req_burst;
          beat_q  <= '0;
          acc_q   <= '0;
          line_q  <= req_write ? req_wline : '0;
          if (req_burst)
            cyc_a <= req_addr & ~((DW'(look_wb) << 2) - DW'(1));
          else
            cyc_a <= req_addr & ~(DW'(look_wb) - DW'(1));
          last_a  <= (req_addr + DW'(req_n) - DW'(1)) & ~(DW'(look_wb) - DW'(1));
          st      <= ST_ADDR;
        end
        ST_ADDR: st <= ST_DATA;
        ST_DATA: if (bus_rdy) begin
          acc_q <= acc_nx;
          if (!wr_q) line_q <= line_nx;
          if (done) begin
            st <= ST_RESP;
          end else begin
            beat_q <= beat_q + 2'd1;
            cyc_a  <= cyc_a + DW'(wb_q);
            st     <= (burst_q && attr_q.burst) ? ST_DATA : ST_ADDR;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign ext_gnt   = gnt_q;
  assign bus_ale   = (st == ST_ADDR);
  assign bus_rd    = (st == ST_DATA) && !wr_q;
  assign bus_wr    = (st == ST_DATA) && wr_q;
  assign bus_oe    = bus_ale || bus_wr;
  assign bus_ad_o  = bus_ale ? cyc_a : (bus_wr ? steer_w : '0);
  assign bus_be    = (st == ST_DATA) ? steer_be : '0;
  assign rsp_valid = (st == ST_RESP);
  assign rsp_rdata = acc_q;
  assign rsp_rline = line_q;
endmodule

// File: rtl/bc_checker.sv
module bc_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_ale,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic          bus_oe,
  input logic          bus_rdy,
  input logic [DW-1:0] bus_ad_o,
  input logic [DW/8-1:0] bus_be,
  input logic          ext_req,
  input logic          ext_gnt,
  input logic          req_ready,
  input logic          rsp_valid
);
  assert_phase_exclusive_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bus_ale, bus_rd, bus_wr}));

  assert_addr_then_data_R1: assert property (@(posedge clk) disable iff (rst)
    bus_ale |=> (bus_rd || bus_wr));

  assert_addr_driven_R1: assert property (@(posedge clk) disable iff (rst)
    bus_ale |-> bus_oe);

  assert_wait_hold_R8: assert property (@(posedge clk) disable iff (rst)
    ((bus_rd || bus_wr) && !bus_rdy) |=>
      ((bus_rd || bus_wr) && !bus_ale && $stable(bus_ad_o) && $stable(bus_be)));

  assert_grant_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    ext_gnt |-> (!bus_ale && !bus_oe && !bus_rd && !bus_wr && !req_ready));

  assert_grant_from_req_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(ext_gnt) |-> $past(ext_req));

  assert_grant_release_R9: assert property (@(posedge clk) disable iff (rst)
    (ext_gnt && !ext_req) |=> !ext_gnt);

  assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
endmodule

bind bus_ctl_top bc_checker #(.DW(DW)) u_bc_checker (
  .clk      (clk),
  .rst      (rst),
  .bus_ale  (bus_ale),
  .bus_rd   (bus_rd),
  .bus_wr   (bus_wr),
  .bus_oe   (bus_oe),
  .bus_rdy  (bus_rdy),
  .bus_ad_o (bus_ad_o),
  .bus_be   (bus_be),
  .ext_req  (ext_req),
  .ext_gnt  (ext_gnt),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid)
);

// File: tb/tb_bus_ctl_top.sv
`timescale 1ns/1ps
module tb_bus_ctl_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
  logic [1:0]   req_size = 2'd2;
  logic [31:0]  req_addr = '0, req_wdata = '0;
  logic [127:0] req_wline = '0;
  logic         req_ready, rsp_valid;
  logic [31:0]  rsp_rdata;
  logic [127:0] rsp_rline;
  logic [31:0]  bus_ad_o, bus_ad_i;
  logic         bus_oe, bus_ale, bus_rd, bus_wr;
  logic [3:0]   bus_be;
  logic         bus_rdy = 1'b1;
  logic         ext_req = 1'b0;
  logic         ext_gnt;

  int checks = 0;
  int errors = 0;
  int stall_every = 0;

  always #4 clk = ~clk;  // 125 MHz

  bus_ctl_top dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_burst(req_burst), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_wline(req_wline),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_rline(rsp_rline),
    .bus_ad_o(bus_ad_o), .bus_ad_i(bus_ad_i), .bus_oe(bus_oe), .bus_ale(bus_ale),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_be(bus_be), .bus_rdy(bus_rdy),
    .ext_req(ext_req), .ext_gnt(ext_gnt)
  );

  // ---------------- device model ----------------
  logic [7:0]  mem [256];
  logic [31:0] dev_a = '0;
  logic [31:0] ale_log [8];
  int ale_cnt = 0, beat_cnt = 0, wait_cnt = 0, rdy_cnt = 0;

  function automatic int midx(input logic [31:0] a);
    return int'({a[13:12], a[5:0]});
  endfunction

  // bench view of the regions (R2, R7): bank 1 = 8-bit BE, 2 = 16-bit LE, 3 = 32-bit LE, else 32-bit BE
  function automatic int dev_w(input logic [31:0] a);
    case (a[13:12])
      2'd1: return 1;
      2'd2: return 2;
      default: return 4;
    endcase
  endfunction

  function automatic logic dev_le(input logic [31:0] a);
    return (a[13:12] == 2'd2) || (a[13:12] == 2'd3);
  endfunction

  always_comb begin
    for (int l = 0; l < 4; l++) bus_ad_i[8*l +: 8] = mem[midx(dev_a + 32'(l))];
  end

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
    end else begin
      if (bus_ale) begin
        dev_a <= bus_ad_o;
        ale_log[ale_cnt % 8] <= bus_ad_o;
        ale_cnt <= ale_cnt + 1;
      end
      if ((bus_rd || bus_wr) && bus_rdy) begin
        beat_cnt <= beat_cnt + 1;
        if (bus_wr)
          for (int l = 0; l < 4; l++)
            if (bus_be[l]) mem[midx(dev_a + 32'(l))] <= bus_ad_o[8*l +: 8];
        dev_a <= dev_a + 32'(dev_w(dev_a));
      end
      if ((bus_rd || bus_wr) && !bus_rdy) wait_cnt <= wait_cnt + 1;
    end
  end

  always @(negedge clk) begin
    rdy_cnt <= rdy_cnt + 1;
    bus_rdy <= (stall_every == 0) || ((rdy_cnt % stall_every) != 0);
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_val(input logic [31:0] a, input int n);
    logic [31:0] v = '0;
    for (int j = 0; j < n; j++) begin
      if (dev_le(a)) v[8*j +: 8] = mem[midx(a + 32'(j))];
      else           v[8*(n-1-j) +: 8] = mem[midx(a + 32'(j))];
    end
    return v;
  endfunction

  function automatic logic [127:0] exp_line(input logic [31:0] base, input int nbytes);
    logic [127:0] v = '0;
    for (int i = 0; i < nbytes; i++) v[8*i +: 8] = mem[midx(base + 32'(i))];
    return v;
  endfunction

  task automatic do_op(input logic wr, input logic bst, input logic [1:0] sz,
                       input logic [31:0] a, input logic [31:0] wd, input logic [127:0] wl,
                       output logic [31:0] rd, output logic [127:0] rl,
                       output int ales, output int beats, output int waits,
                       output logic [31:0] first_a);
    int a0, b0, w0, t;
    a0 = ale_cnt; b0 = beat_cnt; w0 = wait_cnt; t = 0;
    @(negedge clk);
    req_write = wr; req_burst = bst; req_size = sz; req_addr = a;
    req_wdata = wd; req_wline = wl; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && t < 2000) begin @(negedge clk); t++; end
    chk("R10 response arrives", 128'(rsp_valid), 128'(1));
    rd = rsp_rdata; rl = rsp_rline;
    ales = ale_cnt - a0; beats = beat_cnt - b0; waits = wait_cnt - w0;
    first_a = ale_log[a0 % 8];
    @(negedge clk);
    chk("R10 single-cycle response", 128'(rsp_valid), 128'(0));
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    chk("R11 req_ready", 128'(req_ready), 128'(1));
    chk("R11 strobes", 128'({bus_ale, bus_oe, bus_rd, bus_wr, ext_gnt, rsp_valid}), 128'(0));
  endtask

  task automatic t_widths;
    logic [31:0] rd, fa, e; logic [127:0] rl; int na, nb, nw;
    e = exp_val(32'h3004, 4);
    do_op(1'b0, 1'b0, 2'd2, 32'h3004, '0, '0, rd, rl, na, nb, nw, fa);
    chk("R2 32-bit cycles", 128'(na), 128'(1));
    chk("R5 LE word value", 128'(rd), 128'(e));
    e = exp_val(32'h1004, 4);
    do_op(1'b0, 1'b0, 2'd2, 32'h1004, '0, '0, rd, rl, na, nb, nw, fa);
    chk("R2 8-bit cycles", 128'(na), 128'(4));
    chk("R5 BE word value", 128'(rd), 128'(e));
    chk("R1 first address", 128'(fa), 128'(32'h1004));
    e = exp_val(32'h2004, 4);
    do_op(1'b0, 1'b0, 2'd2, 32'h2004, '0, '0, rd, rl, na, nb, nw, fa);
    chk("R2 16-bit cycles", 128'(na), 128'(2));
    chk("R2 16-bit value", 128'(rd), 128'(e));
  endtask

  task automatic t_default;
    logic [31:0] rd, fa, e; logic [127:0] rl; int na, nb, nw;
    e = exp_val(32'h0008, 4);
    do_op(1'b0, 1'b1, 2'd2, 32'h0008, '0, '0, rd, rl, na, nb, nw, fa);
    chk("R7 default region no burst", 128'(na), 128'(4));
    e = exp_val(32'h0008, 4);
    do_op(1'b0, 1'b0, 2'd2, 32'h0008, '0, '0, rd, rl, na, nb, nw, fa);
    chk("R7 default region cycles", 128'(na), 128'(1));
    chk("R7 default BE value", 128'(rd), 128'(e));
  endtask

  task automatic t_misaligned;
    logic [31:0] rd, fa, e; logic [127:0] rl; int na, nb, nw;
    logic [7:0] keep_lo, keep_hi;
    e = exp_val(32'h3001, 4);
    do_op(1'b0, 1'b0, 2'd2, 32'h3001, '0, '0, rd, rl, na, nb, nw, fa);
    chk("R6 misaligned read cycles", 128'(na), 128'(2));
    chk("R6 misaligned read value", 128'(rd), 128'(e));
    chk("R6 first aligned address", 128'(fa), 128'(32'h3000));
    keep_lo = mem[midx(32'h3005)]; keep_hi = mem[midx(32'h300A)];
    do_op(1'b1, 1'b0, 2'd2, 32'h3006, 32'hA1B2C3D4, '0, rd, rl, na, nb, nw, fa);
    chk("R6 misaligned write cycles", 128'(na), 128'(2));
    chk("R6 written bytes", 128'({mem[midx(32'h3009)], mem[midx(32'h3008)], mem[midx(32'h3007)], mem[midx(32'h3006)]}),
        128'(32'hA1B2C3D4));
    chk("R6 neighbours untouched", 128'({mem[midx(32'h300A)], mem[midx(32'h3005)]}), 128'({keep_hi, keep_lo}));
    do_op(1'b1, 1'b0, 2'd1, 32'h1011, 32'h0000BEEF, '0, rd, rl, na, nb, nw, fa);
    chk("R5 BE half write order", 128'({mem[midx(32'h1011)], mem[midx(32'h1012)]}), 128'(16'hBEEF));
    chk("R6 8-bit half cycles", 128'(na), 128'(2));
    keep_lo = mem[midx(32'h2004)];
    do_op(1'b1, 1'b0, 2'd0, 32'h2005, 32'h00000077, '0, rd, rl, na, nb, nw, fa);
    chk("R2 upper lane byte write", 128'({mem[midx(32'h2005)], mem[midx(32'h2004)]}), 128'({8'h77, keep_lo}));
  endtask

  task automatic t_burst;
    logic [31:0] rd, fa; logic [127:0] rl, e; int na, nb, nw;
    logic [7:0] keep;
    e = exp_line(32'h3010, 16);
    do_op(1'b0, 1'b1, 2'd2, 32'h3014, '0, '0, rd, rl, na, nb, nw, fa);
    chk("R3 burst address phases", 128'(na), 128'(1));
    chk("R3 burst beats", 128'(nb), 128'(4));
    chk("R3 burst base", 128'(fa), 128'(32'h3010));
    chk("R3 burst line", rl, e);
    stall_every = 3;
    e = exp_line(32'h3020, 16);
    do_op(1'b0, 1'b1, 2'd2, 32'h3020, '0, '0, rd, rl, na, nb, nw, fa);
    chk("R8 waits seen", 128'(nw > 0), 128'(1));
    chk("R8 burst not restarted", 128'(na), 128'(1));
    chk("R8 line with waits", rl, e);
    stall_every = 0;
    keep = mem[midx(32'h1024)];
    do_op(1'b1, 1'b1, 2'd2, 32'h1023, '0, 128'h11223344, rd, rl, na, nb, nw, fa);
    chk("R3 8-bit burst phases", 128'({na[7:0], nb[7:0]}), 128'(16'h0104));
    chk("R3 8-bit burst bytes", 128'({mem[midx(32'h1023)], mem[midx(32'h1022)], mem[midx(32'h1021)], mem[midx(32'h1020)], mem[midx(32'h1024)]}),
        128'({32'h11223344, keep}));
  endtask

  task automatic t_noburst;
    logic [31:0] rd, fa; logic [127:0] rl, e; int na, nb, nw;
    e = exp_line(32'h2030, 8);
    do_op(1'b0, 1'b1, 2'd2, 32'h2030, '0, '0, rd, rl, na, nb, nw, fa);
    chk("R4 separate address phases", 128'(na), 128'(4));
    chk("R4 first address", 128'(fa), 128'(32'h2030));
    chk("R4 line value", rl, e);
  endtask

  task automatic t_master;
    int a0, t; logic [31:0] e;
    e = exp_val(32'h3008, 4);
    @(negedge clk); ext_req = 1'b1;
    @(negedge clk);
    chk("R9 grant next clock", 128'(ext_gnt), 128'(1));
    chk("R9 not ready while granted", 128'(req_ready), 128'(0));
    req_write = 1'b0; req_burst = 1'b0; req_size = 2'd2; req_addr = 32'h3008; req_valid = 1'b1;
    a0 = ale_cnt;
    repeat (4) @(negedge clk);
    chk("R9 no cycle while granted", 128'({ale_cnt - a0, 31'(bus_oe)}), 128'(0));
    ext_req = 1'b0;
    @(negedge clk);
    chk("R9 grant released", 128'(ext_gnt), 128'(0));
    while (!req_ready) @(negedge clk);
    @(negedge clk); req_valid = 1'b0;
    t = 0;
    while (!rsp_valid && t < 2000) begin @(negedge clk); t++; end
    chk("R9 request served after release", 128'(rsp_rdata), 128'(e));
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_widths;
    t_default;
    t_misaligned;
    t_burst;
    t_noburst;
    t_master;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
    $finish;
  end
endmodule